// File: doc/BRIEF.md
# Sensorless Commutation Clock Generator

This block drives the commutation timing of a three-phase sensorless spindle. It takes the frequency-generator (FG) signal derived from back-EMF zero crossings, rejects short glitches on it, and times the gap between accepted FG edges in ticks of a parameterised time base (1 µs by default). Each edge produces one commutation pulse and a blanking mask. The pulse and the mask are placed as fixed shifts of the last measured interval.

There are three modes. At standstill the block runs open loop and emits forced commutations from a fixed timer. Once FG edges appear in two consecutive forced periods, it switches to self-commutation with a coarse delay. When the speed loop asks for it, a fine delay and a fixed short mask are used instead, which also selects soft commutation in the driver. If FG stops long enough for the interval counter to saturate, the block gives up self-commutation, flags a retry and restarts open loop.

Top module: `comm_clock_gen`

## Requirements
- R1: While `rst_n` is low, `comm`, `mask` and `retry` are 0 and `mode` is 0 (start-up).
- R2: In start-up (`mode`=0), `comm` pulses once every SU_PERIOD ticks (the first pulse at tick SU_PERIOD after reset release), and `mask` is high for SU_MASK ticks starting with each pulse.
- R3: `fg_raw` must hold a new level for FILT_LEN consecutive clocks before it counts as an FG edge. The edge is taken on the FILT_LEN-th clock edge after the change. A shorter pulse produces no edge.
- R4: An FG edge taken while `mask` is high is ignored. It does not restart the interval measurement, it does not change the mode and it produces no commutation.
- R5: In start-up, an accepted FG edge moves `mode` to 1 (acceleration) only if the previous forced-commutation period also contained an accepted edge. The interval between those two edges becomes the stored interval.
- R6: When an edge is accepted and the resulting mode is acceleration, `comm` pulses P>>1 ticks after the edge, where P is the interval in ticks that the edge closes. `mask` then stays high for P>>2 ticks.
- R7: If `run_req` is 1 when an edge is accepted in acceleration or running mode, `mode` becomes 2 (running). `comm` then follows P>>5 ticks after the edge and `mask` lasts RUN_MASK ticks.
- R8: If `run_req` is 0 when an edge is accepted in running or acceleration mode, `mode` becomes or stays 1.
- R9: In acceleration or running mode, when the interval counter reaches its all-ones value and another tick passes without an edge, `retry` pulses for one clock. `mode` returns to 0 and the forced timer restarts, so the next `comm` follows SU_PERIOD ticks later.
- R10: `mode` encodes 0 as start-up, 1 as acceleration (hard commutation) and 2 as running (soft commutation). The value 3 never appears.
- R11: `comm` is one clock wide, and `mask` rises in the same cycle as each `comm` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fg_raw | input | 1 | Unfiltered FG signal from zero-cross detection |
| run_req | input | 1 | Request for running mode (fine delay, soft commutation) |
| comm | output | 1 | Commutation pulse, one clock wide |
| mask | output | 1 | Blanking window for FG after commutation |
| mode | output | 2 | 0 start-up, 1 acceleration, 2 running |
| retry | output | 1 | One-clock pulse when self-commutation is abandoned |

## Verification
Almost every internal fault moves a pulse in time, so the bench pins each `comm` to an exact cycle after the filtered FG edge it answers. It also counts the `mask` cycles, so a wrong shift, a wrong stored interval or an off-by-one filter shows up at the first commutation after the faulty edge. A masked or glitch edge that is wrongly accepted would produce an extra `comm` in a window where none is expected, and the next delay would be wrong. A broken start-up lock criterion or a broken saturation path shows up as the wrong `mode` or a misplaced `retry`, within one forced period or one counter span.

// File: rtl/comm_clock_gen.sv
module comm_clock_gen #(
  parameter int TICK_DIV  = 125,
  parameter int CNT_W     = 16,
  parameter int SU_PERIOD = 2000,
  parameter int SU_MASK   = 1000,
  parameter int RUN_MASK  = 344,
  parameter int FILT_LEN  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fg_raw,
  input  logic       run_req,
  output logic       comm,
  output logic       mask,
  output logic [1:0] mode,
  output logic       retry
);
  localparam int TW  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int FW  = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam int PW  = $clog2(SU_PERIOD + 1);
  localparam int MW0 = ($clog2(SU_MASK + 1) > CNT_W) ? $clog2(SU_MASK + 1) : CNT_W;
  localparam int MW  = ($clog2(RUN_MASK + 1) > MW0) ? $clog2(RUN_MASK + 1) : MW0;
  localparam logic [1:0] M_START = 2'd0;
  localparam logic [1:0] M_ACCEL = 2'd1;
  localparam logic [1:0] M_RUN   = 2'd2;
  localparam logic [CNT_W-1:0] IVL_MAX = '1;

  logic [TW-1:0]    tcnt;
  logic             tick;
  logic             fg_filt;
  logic [FW-1:0]    fcnt;
  logic             fg_edge, edge_ok;
  logic [CNT_W-1:0] ivl, stored, dly, dly_load;
  logic [MW-1:0]    mcnt, mlen;
  logic [PW-1:0]    spc;
  logic             pend, seen_cur, seen_prev;
  logic             take, sat, fire_self, fire_su, fire;
  logic [1:0]       nmode;

  assign tick = (tcnt == TW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= '0;
    else        tcnt <= tick ? '0 : tcnt + 1'b1;

  assign fg_edge = (fg_raw != fg_filt) && (fcnt == FW'(FILT_LEN - 1));
  assign edge_ok = fg_edge && !mask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fg_filt <= 1'b0;
      fcnt    <= '0;
    end else if (fg_raw == fg_filt) begin
      fcnt    <= '0;
    end else if (fg_edge) begin
      fg_filt <= fg_raw;
      fcnt    <= '0;
    end else begin
      fcnt    <= fcnt + 1'b1;
    end

  assign nmode     = (mode == M_START) ? M_ACCEL : (run_req ? M_RUN : M_ACCEL);
  assign dly_load  = (nmode == M_RUN) ? (ivl >> 5) : (ivl >> 1);
  assign take      = edge_ok && ((mode != M_START) || seen_prev);
  assign sat       = tick && (ivl == IVL_MAX) && (mode != M_START);
  assign fire_self = pend && tick && (dly <= CNT_W'(1)) && !sat;
  assign fire_su   = (mode == M_START) && tick && (spc == PW'(SU_PERIOD - 1)) && !take;
  assign fire      = fire_self || fire_su;
  assign mlen      = (mode == M_START) ? MW'(SU_MASK) :
                     (mode == M_RUN)   ? MW'(RUN_MASK) : MW'(stored >> 2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode      <= M_START;
      comm      <= 1'b0;
      retry     <= 1'b0;
      mask      <= 1'b0;
      mcnt      <= '0;
      ivl       <= '0;
      stored    <= '0;
      dly       <= '0;
      pend      <= 1'b0;
      spc       <= '0;
      seen_cur  <= 1'b0;
      seen_prev <= 1'b0;
    end else begin
      comm  <= fire;
      retry <= sat;

      if (edge_ok)                       ivl <= CNT_W'(1);
      else if (tick && ivl != IVL_MAX)   ivl <= ivl + 1'b1;

      if (sat) begin
        mode      <= M_START;
        pend      <= 1'b0;
        spc       <= '0;
        seen_cur  <= 1'b0;
        seen_prev <= 1'b0;
      end else begin
        if (take) begin
          mode   <= nmode;
          stored <= ivl;
          pend   <= 1'b1;
          dly    <= dly_load;
        end else if (pend && tick) begin
          if (dly <= CNT_W'(1)) pend <= 1'b0;
          else                  dly  <= dly - 1'b1;
        end

        if (mode == M_START && !take) begin
          if (tick) spc <= (spc == PW'(SU_PERIOD - 1)) ? '0 : spc + 1'b1;
          if (fire_su) begin
            seen_prev <= seen_cur || edge_ok;
            seen_cur  <= 1'b0;
          end else if (edge_ok) begin
            seen_cur  <= 1'b1;
          end
        end else begin
          spc <= '0;
        end
      end

      if (sat) begin
        mask <= 1'b0;
      end else if (fire) begin
        mask <= 1'b1;
        mcnt <= mlen;
      end else if (mask && tick) begin
        if (mcnt <= MW'(1)) mask <= 1'b0;
        else                mcnt <= mcnt - 1'b1;
      end
    end

  assert_comm_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    comm |=> !comm);
  assert_mask_with_comm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    comm |-> mask);
  assert_retry_startup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> (mode == M_START));
  assert_mode_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);
  assert_run_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_RUN && $past(mode) != M_RUN) |-> $past(run_req));
  assert_mask_holds_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask |=> ($stable(mode) || retry));
endmodule

// File: tb/comm_clock_gen_bench.sv
module comm_clock_gen_bench;
  logic clk = 1'b0, rst_n = 1'b0, fg_raw = 1'b0, run_req = 1'b0;
  logic comm, mask, retry;
  logic [1:0] mode;
  int cyc = 0, total = 0, bad = 0, t_last = 0;
  int n_comm, first_comm, n_mask, n_retry, first_retry;
  int base;
  bit done = 1'b0;

  localparam int NV = 8;
  localparam int VP[NV]   = '{40, 35, 66, 96, 160, 40, 200, 250};
  localparam int VR[NV]   = '{0, 0, 1, 1, 1, 0, 0, 0};
  localparam int VMODE[NV] = '{1, 1, 2, 2, 2, 1, 1, 1};
  localparam int VD[NV]   = '{20, 17, 2, 3, 5, 20, 100, 125};
  localparam int VM[NV]   = '{10, 8, 7, 7, 7, 10, 50, 62};

  comm_clock_gen #(.TICK_DIV(1), .CNT_W(8), .SU_PERIOD(40), .SU_MASK(20),
                   .RUN_MASK(7), .FILT_LEN(3)) u_comm_clock_gen (
    .clk(clk), .rst_n(rst_n), .fg_raw(fg_raw), .run_req(run_req),
    .comm(comm), .mask(mask), .mode(mode), .retry(retry));

  always #4 clk = ~clk;

  always @(posedge clk)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic adv();
    @(posedge clk);
    #2;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) adv();
  endtask

  task automatic toggle();
    fg_raw = ~fg_raw;
    t_last = cyc;
  endtask

  task automatic run_window(input int n);
    n_comm = 0; first_comm = -1; n_mask = 0; n_retry = 0; first_retry = -1;
    for (int i = 0; i < n; i++) begin
      adv();
      if (comm) begin
        n_comm++;
        if (first_comm < 0) first_comm = cyc;
      end
      if (mask) n_mask++;
      if (retry) begin
        n_retry++;
        if (first_retry < 0) first_retry = cyc;
      end
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(comm == 0 && mask == 0 && retry == 0, "R1 outputs in reset", {comm, mask, retry}, 0);
    chk(mode == 0, "R1 mode in reset", mode, 0);
    rst_n = 1'b1;

    run_window(60);
    chk(first_comm == 40, "R2 first forced pulse", first_comm, 40);
    chk(n_comm == 1, "R2 pulse count", n_comm, 1);
    chk(n_mask == 20, "R2 mask width", n_mask, 20);
    run_window(40);
    chk(first_comm == 80, "R2 forced period", first_comm, 80);
    chk(n_mask == 20, "R2 second mask width", n_mask, 20);

    wait_until(122); toggle();
    wait_until(185); toggle();
    wait_until(195);
    chk(mode == 0, "R4 masked edge in start-up does not count", mode, 0);
    wait_until(225); toggle();
    run_window(34);
    chk(mode == 1, "R5 lock to acceleration", mode, 1);
    chk(first_comm == 248, "R5 delay from stored interval", first_comm, 248);
    chk(n_comm == 1, "R5 forced timer stops", n_comm, 1);
    chk(n_mask == 10, "R6 mask after lock", n_mask, 10);

    for (int v = 0; v < NV; v++) begin
      wait_until(t_last + VP[v]);
      run_req = VR[v][0];
      toggle();
      base = t_last;
      run_window(VD[v] + VM[v] + 4);
      chk(first_comm == base + 3 + VD[v], (VMODE[v] == 2) ? "R7 fine delay" : "R6 coarse delay",
          first_comm - base, 3 + VD[v]);
      chk(n_comm == 1, "R11 one pulse per edge", n_comm, 1);
      chk(n_mask == VM[v], (VMODE[v] == 2) ? "R7 fixed mask" : "R6 quarter mask", n_mask, VM[v]);
      chk(mode == VMODE[v], (VMODE[v] == 2) ? "R7 running mode" : "R8 acceleration mode",
          mode, VMODE[v]);
    end

    wait_until(t_last + 200);
    toggle();
    base = t_last;
    run_window(108);
    chk(first_comm == base + 103, "R6 delay before masked edge", first_comm - base, 103);
    toggle();
    run_window(59);
    chk(n_comm == 0, "R4 masked edge gives no pulse", n_comm, 0);
    chk(mode == 1, "R4 mode unchanged", mode, 1);
    wait_until(base + 170);
    toggle();
    base = t_last;
    run_window(135);
    chk(first_comm == base + 88, "R4 interval spans masked edge", first_comm - base, 88);
    chk(n_mask == 42, "R4 mask from spanned interval", n_mask, 42);

    wait_until(base + 140);
    fg_raw = ~fg_raw;
    run_window(2);
    fg_raw = ~fg_raw;
    run_window(37);
    chk(n_comm == 0, "R3 glitch gives no pulse", n_comm, 0);
    wait_until(base + 180);
    toggle();
    base = t_last;
    run_window(140);
    chk(first_comm == base + 93, "R3 glitch not measured", first_comm - base, 93);
    chk(n_mask == 45, "R3 mask after glitch", n_mask, 45);

    run_window(300);
    chk(first_retry == base + 258, "R9 retry on saturation", first_retry - base, 258);
    chk(n_retry == 1, "R9 single retry", n_retry, 1);
    chk(first_comm == base + 298, "R9 forced timer restarts", first_comm - base, 298);
    chk(mode == 0, "R9 back to start-up", mode, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule